// File: doc/BRIEF.md
# Branch Resolution and Condition-Bit Logic Unit

This unit sits behind instruction dispatch. It takes conditional and unconditional branches into a two-entry waiting queue, together with the direction and target address that the front end guessed for them. When the condition-register image is marked valid, the oldest waiting branch is evaluated. The unit computes the real direction and the real destination, and compares both against the guess. A wrong guess produces a one-cycle fetch redirect to the right address and a recovery request that carries the branch tag. The wrong guess also discards every younger branch still waiting.

A resolved branch moves into a second two-entry queue and stays there until the completion logic retires it. When that queue is full, evaluation pauses. Alongside the branch path, the unit performs single-bit boolean operations between two condition-register bits. It returns the result bit and its destination index one cycle later, ready to be written back.

Top module: `brx_unit`

## Requirements
- R1: The waiting queue holds at most two branches; `disp_ready` is low while it holds two, and a dispatch offered while `disp_ready` is low is ignored and never resolves.
- R2: The resolved queue holds at most two branches; while it holds two, no branch resolves (`done_valid` stays low) even with `cr_valid` high, and resolution resumes after a retirement frees a slot.
- R3: Branches resolve and retire in the order they were dispatched.
- R4: The real direction follows `disp_kind`: 0 always taken, 1 taken when `cr_bits[disp_crbit]` is 1, 2 taken when that bit is 0, 3 never taken. A predicted direction that differs is a misprediction, and the correct address is `pc+ofs` when taken, else `pc+4`.
- R5: When a branch is predicted taken and is taken, a predicted target different from `pc+ofs` is a misprediction; when it is predicted not taken and is not taken, the predicted target is ignored.
- R6: A branch resolved in cycle T shows `done_valid` with its tag in cycle T+1. In that same cycle a misprediction raises `redir_valid` with the correct address and `recov_valid` with the branch tag, each for exactly one cycle. A correct prediction raises neither.
- R7: A misprediction discards every branch still in the waiting queue and any branch dispatched in the cycle it resolves; older branches already in the resolved queue are kept.
- R8: `ret_valid`/`ret_tag` present the oldest resolved branch; `cmpl_valid` retires it, and `cmpl_valid` with the resolved queue empty has no effect.
- R9: No branch resolves while `cr_valid` is low.
- R10: A condition-bit operation accepted in cycle T presents `crl_wr_valid`, `crl_wr_idx` = destination and `crl_wr_bit` in cycle T+1. `crl_op` is 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 EQV, 6 A AND NOT B, 7 A OR NOT B, on bits `cr_bits[crl_src_a]` and `cr_bits[crl_src_b]`.
- R11: After reset both queues are empty, `disp_ready` is high, and every valid output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| disp_valid | input | 1 | Branch offered for dispatch |
| disp_ready | output | 1 | Waiting queue has room |
| disp_tag | input | TAG_W | Branch tag |
| disp_kind | input | 2 | Condition kind (see R4) |
| disp_crbit | input | CIW | Condition bit index |
| disp_pc | input | AW | Branch address |
| disp_ofs | input | AW | Target offset |
| disp_pred_taken | input | 1 | Predicted direction |
| disp_pred_tgt | input | AW | Predicted target |
| cr_valid | input | 1 | Condition-register image ready |
| cr_bits | input | CRN | Condition-register image |
| done_valid | output | 1 | A branch resolved last cycle |
| done_tag | output | TAG_W | Tag of the resolved branch |
| done_taken | output | 1 | Its real direction |
| done_mispred | output | 1 | Its prediction was wrong |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_addr | output | AW | Correct fetch address |
| recov_valid | output | 1 | Recovery request pulse |
| recov_tag | output | TAG_W | Mispredicted branch tag |
| ret_valid | output | 1 | Resolved queue not empty |
| ret_tag | output | TAG_W | Oldest resolved tag |
| cmpl_valid | input | 1 | Retire the oldest resolved branch |
| crl_valid | input | 1 | Condition-bit operation request |
| crl_op | input | 3 | Operation code (see R10) |
| crl_src_a | input | CIW | First source bit index |
| crl_src_b | input | CIW | Second source bit index |
| crl_dst | input | CIW | Destination bit index |
| crl_wr_valid | output | 1 | Result valid |
| crl_wr_idx | output | CIW | Result destination |
| crl_wr_bit | output | 1 | Result bit |

## Verification
On every cycle the assertions check the occupancy limits of both queues and the pause in resolution while the resolved queue is full. They also check that redirect and recovery arrive together as single-cycle pulses with the resolved tag, that the waiting queue is empty after a misprediction, and that a condition-bit result follows its request by one cycle. Only the directed scenarios can show the correctness of the values themselves. These are the evaluated direction for each condition kind, the target comparison, the redirect address, and the tag order. The scenarios also show that a refused or flushed dispatch never resolves, and they give the result bit of every logical operation.

// File: rtl/brx_pkg.sv
package brx_pkg;
  typedef enum logic [1:0] {
    BK_ALWAYS = 2'd0,
    BK_IF_SET = 2'd1,
    BK_IF_CLR = 2'd2,
    BK_NEVER  = 2'd3
  } brx_kind_e;

  typedef enum logic [2:0] {
    CL_AND  = 3'd0,
    CL_OR   = 3'd1,
    CL_XOR  = 3'd2,
    CL_NAND = 3'd3,
    CL_NOR  = 3'd4,
    CL_EQV  = 3'd5,
    CL_ANDC = 3'd6,
    CL_ORC  = 3'd7
  } crl_op_e;

  function automatic logic crl_apply(input crl_op_e op, input logic a, input logic b);
    logic r;
    case (op)
      CL_AND:  r = a & b;
      CL_OR:   r = a | b;
      CL_XOR:  r = a ^ b;
      CL_NAND: r = ~(a & b);
      CL_NOR:  r = ~(a | b);
      CL_EQV:  r = ~(a ^ b);
      CL_ANDC: r = a & ~b;
      default: r = a | ~b;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/brx_queue.sv
module brx_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  input  logic          clear,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !clear;
  assign do_pop  = pop && !empty;
  assign count   = cnt_q;
  assign dout    = mem_q[rd_q];

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (clear) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = ptr_inc(wr_q);
      if (do_pop)  rd_d = ptr_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wr_q == PW'(i))) mem_q[i] <= din;
    end
  end
endmodule

// File: rtl/brx_eval.sv
module brx_eval
  import brx_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CRN  = 32,
  parameter int STEP = 4,
  localparam int CIW = $clog2(CRN)
) (
  input  logic [1:0]     kind,
  input  logic [CIW-1:0] crbit,
  input  logic [CRN-1:0] cr_bits,
  input  logic [AW-1:0]  pc,
  input  logic [AW-1:0]  ofs,
  input  logic           pred_taken,
  input  logic [AW-1:0]  pred_tgt,
  output logic           taken,
  output logic [AW-1:0]  fetch_addr,
  output logic           mispred
);
  logic          sel_bit;
  logic [AW-1:0] tgt_addr, seq_addr;
  logic          dir_miss, tgt_miss;

  assign sel_bit  = cr_bits[crbit];
  assign tgt_addr = pc + ofs;
  assign seq_addr = pc + AW'(STEP);

  always_comb begin
    case (brx_kind_e'(kind))
      BK_ALWAYS: taken = 1'b1;
      BK_IF_SET: taken = sel_bit;
      BK_IF_CLR: taken = ~sel_bit;
      default:   taken = 1'b0;
    endcase
  end

  assign fetch_addr = taken ? tgt_addr : seq_addr;
  assign dir_miss   = (taken != pred_taken);
  assign tgt_miss   = taken && pred_taken && (pred_tgt != tgt_addr);
  assign mispred    = dir_miss || tgt_miss;
endmodule

// File: rtl/brx_crl.sv
module brx_crl
  import brx_pkg::*;
#(
  parameter int CRN  = 32,
  localparam int CIW = $clog2(CRN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [2:0]     op,
  input  logic [CIW-1:0] src_a,
  input  logic [CIW-1:0] src_b,
  input  logic [CIW-1:0] dst,
  input  logic [CRN-1:0] cr_bits,
  output logic           out_valid,
  output logic [CIW-1:0] out_idx,
  output logic           out_bit
);
  logic           res_d;
  logic           vld_q;
  logic [CIW-1:0] idx_q;
  logic           bit_q;

  always_comb res_d = crl_apply(crl_op_e'(op), cr_bits[src_a], cr_bits[src_b]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      idx_q <= dst;
      bit_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign out_idx   = idx_q;
  assign out_bit   = bit_q;
endmodule

// File: rtl/brx_unit.sv
module brx_unit
  import brx_pkg::*;
#(
  parameter int TAG_W    = 4,
  parameter int AW       = 32,
  parameter int CRN      = 32,
  parameter int RS_DEPTH = 2,
  parameter int CB_DEPTH = 2,
  parameter int STEP     = 4,
  localparam int CIW     = $clog2(CRN),
  localparam int RSC_W   = $clog2(RS_DEPTH + 1),
  localparam int CBC_W   = $clog2(CB_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  output logic             disp_ready,
  input  logic [TAG_W-1:0] disp_tag,
  input  logic [1:0]       disp_kind,
  input  logic [CIW-1:0]   disp_crbit,
  input  logic [AW-1:0]    disp_pc,
  input  logic [AW-1:0]    disp_ofs,
  input  logic             disp_pred_taken,
  input  logic [AW-1:0]    disp_pred_tgt,
  input  logic             cr_valid,
  input  logic [CRN-1:0]   cr_bits,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag,
  output logic             done_taken,
  output logic             done_mispred,
  output logic             redir_valid,
  output logic [AW-1:0]    redir_addr,
  output logic             recov_valid,
  output logic [TAG_W-1:0] recov_tag,
  output logic             ret_valid,
  output logic [TAG_W-1:0] ret_tag,
  input  logic             cmpl_valid,
  input  logic             crl_valid,
  input  logic [2:0]       crl_op,
  input  logic [CIW-1:0]   crl_src_a,
  input  logic [CIW-1:0]   crl_src_b,
  input  logic [CIW-1:0]   crl_dst,
  output logic             crl_wr_valid,
  output logic [CIW-1:0]   crl_wr_idx,
  output logic             crl_wr_bit
);
  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [1:0]       kind;
    logic [CIW-1:0]   crbit;
    logic [AW-1:0]    pc;
    logic [AW-1:0]    ofs;
    logic             pred_taken;
    logic [AW-1:0]    pred_tgt;
  } wait_ent_t;

  localparam int EW = $bits(wait_ent_t);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  wait_ent_t        new_ent, head_ent;
  logic [EW-1:0]    head_raw;
  logic [RSC_W-1:0] rs_cnt;
  logic [CBC_W-1:0] cb_cnt;
  logic             rs_full, rs_empty, cb_full, cb_empty;
  logic             rslv, flush, rs_push, cb_pop;
  logic             ev_taken, ev_mispred;
  logic [AW-1:0]    ev_addr;

  assign new_ent = '{tag: disp_tag, kind: disp_kind, crbit: disp_crbit, pc: disp_pc,
                     ofs: disp_ofs, pred_taken: disp_pred_taken, pred_tgt: disp_pred_tgt};
  assign head_ent = wait_ent_t'(head_raw);

  assign rslv       = !rs_empty && cr_valid && !cb_full;
  assign flush      = rslv && ev_mispred;
  assign disp_ready = !rs_full;
  assign rs_push    = disp_valid && disp_ready && !flush;
  assign cb_pop     = cmpl_valid && !cb_empty;

  brx_queue #(.W(EW), .DEPTH(RS_DEPTH)) wait_q_i (
    .clk(clk), .rst_n(rst_sync_n),
    .push(rs_push), .din(new_ent), .pop(rslv), .clear(flush),
    .dout(head_raw), .count(rs_cnt), .full(rs_full), .empty(rs_empty)
  );

  brx_eval #(.AW(AW), .CRN(CRN), .STEP(STEP)) eval_i (
    .kind(head_ent.kind), .crbit(head_ent.crbit), .cr_bits(cr_bits),
    .pc(head_ent.pc), .ofs(head_ent.ofs),
    .pred_taken(head_ent.pred_taken), .pred_tgt(head_ent.pred_tgt),
    .taken(ev_taken), .fetch_addr(ev_addr), .mispred(ev_mispred)
  );

  brx_queue #(.W(TAG_W), .DEPTH(CB_DEPTH)) done_q_i (
    .clk(clk), .rst_n(rst_sync_n),
    .push(rslv), .din(head_ent.tag), .pop(cb_pop), .clear(1'b0),
    .dout(ret_tag), .count(cb_cnt), .full(cb_full), .empty(cb_empty)
  );

  assign ret_valid = !cb_empty;

  // resolution report and redirect registers
  logic             dv_d, dm_d, rv_d;
  logic             dv_q, dm_q, dt_q, rv_q;
  logic [TAG_W-1:0] tag_q;
  logic [AW-1:0]    addr_q;

  always_comb begin
    dv_d = rslv;
    dm_d = rslv && ev_mispred;
    rv_d = rslv && ev_mispred;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dv_q <= 1'b0;
      dm_q <= 1'b0;
      rv_q <= 1'b0;
    end else begin
      dv_q <= dv_d;
      dm_q <= dm_d;
      rv_q <= rv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rslv) begin
      tag_q  <= head_ent.tag;
      dt_q   <= ev_taken;
      addr_q <= ev_addr;
    end
  end

  assign done_valid   = dv_q;
  assign done_tag     = tag_q;
  assign done_taken   = dt_q;
  assign done_mispred = dm_q;
  assign redir_valid  = rv_q;
  assign redir_addr   = addr_q;
  assign recov_valid  = rv_q;
  assign recov_tag    = tag_q;

  brx_crl #(.CRN(CRN)) crl_i (
    .clk(clk), .rst_n(rst_sync_n),
    .in_valid(crl_valid), .op(crl_op), .src_a(crl_src_a), .src_b(crl_src_b),
    .dst(crl_dst), .cr_bits(cr_bits),
    .out_valid(crl_wr_valid), .out_idx(crl_wr_idx), .out_bit(crl_wr_bit)
  );
endmodule

// File: rtl/brx_chk.sv
module brx_chk #(
  parameter int TAG_W    = 4,
  parameter int RS_DEPTH = 2,
  parameter int CB_DEPTH = 2,
  localparam int RSC_W   = $clog2(RS_DEPTH + 1),
  localparam int CBC_W   = $clog2(CB_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [RSC_W-1:0] rs_cnt,
  input logic [CBC_W-1:0] cb_cnt,
  input logic             done_valid,
  input logic             done_mispred,
  input logic [TAG_W-1:0] done_tag,
  input logic             redir_valid,
  input logic             recov_valid,
  input logic [TAG_W-1:0] recov_tag,
  input logic             crl_valid,
  input logic             crl_wr_valid
);
  // R1
  rs_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_cnt <= RSC_W'(RS_DEPTH));

  // R2
  cb_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cb_cnt <= CBC_W'(CB_DEPTH));

  // R2
  cb_full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_cnt == CBC_W'(CB_DEPTH)) |=> !done_valid);

  // R6
  redir_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !redir_valid);

  // R6
  redir_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid == recov_valid) && (redir_valid == (done_valid && done_mispred)));

  // R6
  recov_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recov_valid |-> (recov_tag == done_tag));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (rs_cnt == '0));

  // R10
  crl_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crl_valid |=> crl_wr_valid);

  // R10
  crl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !crl_valid |=> !crl_wr_valid);
endmodule

bind brx_unit brx_chk #(.TAG_W(TAG_W), .RS_DEPTH(RS_DEPTH), .CB_DEPTH(CB_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .rs_cnt(rs_cnt), .cb_cnt(cb_cnt),
  .done_valid(done_valid), .done_mispred(done_mispred), .done_tag(done_tag),
  .redir_valid(redir_valid), .recov_valid(recov_valid), .recov_tag(recov_tag),
  .crl_valid(crl_valid), .crl_wr_valid(crl_wr_valid)
);

// File: tb/brx_unit_tb_top.sv
module brx_unit_tb_top;
  localparam int TAG_W = 4;
  localparam int AW    = 32;
  localparam int CRN   = 32;
  localparam int CIW   = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             disp_valid, disp_ready, disp_pred_taken;
  logic [TAG_W-1:0] disp_tag;
  logic [1:0]       disp_kind;
  logic [CIW-1:0]   disp_crbit;
  logic [AW-1:0]    disp_pc, disp_ofs, disp_pred_tgt;
  logic             cr_valid;
  logic [CRN-1:0]   cr_bits;
  logic             done_valid, done_taken, done_mispred;
  logic [TAG_W-1:0] done_tag, recov_tag, ret_tag;
  logic             redir_valid, recov_valid, ret_valid, cmpl_valid;
  logic [AW-1:0]    redir_addr;
  logic             crl_valid, crl_wr_valid, crl_wr_bit;
  logic [2:0]       crl_op;
  logic [CIW-1:0]   crl_src_a, crl_src_b, crl_dst, crl_wr_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  brx_unit dut_i (.*);

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_take(input logic [1:0] k, input logic b);
    case (k)
      2'd0:    return 1'b1;
      2'd1:    return b;
      2'd2:    return ~b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic dispatch(input logic [3:0] tag, input logic [1:0] kind, input logic [4:0] cb,
                          input logic [31:0] pc, input logic [31:0] ofs,
                          input logic pt, input logic [31:0] ptgt);
    @(negedge clk);
    disp_valid = 1'b1; disp_tag = tag; disp_kind = kind; disp_crbit = cb;
    disp_pc = pc; disp_ofs = ofs; disp_pred_taken = pt; disp_pred_tgt = ptgt;
    @(negedge clk);
    disp_valid = 1'b0;
  endtask

  task automatic resolve(input string req, input logic [3:0] tag, input logic mis, input logic [31:0] addr);
    @(negedge clk);
    cr_valid = 1'b1;
    @(negedge clk);
    cr_valid = 1'b0;
    check(req, "done_valid", 32'(done_valid), 32'd1);
    check("R3", "done_tag", 32'(done_tag), 32'(tag));
    check(req, "mispred", 32'(done_mispred), 32'(mis));
    check("R6", "redir_valid", 32'(redir_valid), 32'(mis));
    check("R6", "recov_valid", 32'(recov_valid), 32'(mis));
    if (mis) begin
      check(req, "redir_addr", redir_addr, addr);
      check("R6", "recov_tag", 32'(recov_tag), 32'(tag));
    end
    @(negedge clk);
    check("R6", "redirect pulse ends", 32'(redir_valid), 32'd0);
  endtask

  task automatic retire(input logic [3:0] tag);
    @(negedge clk);
    check("R8", "ret_valid", 32'(ret_valid), 32'd1);
    check("R8", "ret_tag", 32'(ret_tag), 32'(tag));
    cmpl_valid = 1'b1;
    @(negedge clk);
    cmpl_valid = 1'b0;
  endtask

  task automatic expect_no_resolve(input string req);
    @(negedge clk);
    cr_valid = 1'b1;
    @(negedge clk);
    cr_valid = 1'b0;
    check(req, "no resolution", 32'(done_valid), 32'd0);
  endtask

  task automatic run_branch(input string req, input logic [3:0] tag, input logic [1:0] kind,
                            input logic [4:0] cb, input logic [31:0] pc, input logic [31:0] ofs,
                            input logic pt, input logic [31:0] ptgt);
    logic tk, mis;
    logic [31:0] addr;
    tk   = exp_take(kind, cr_bits[cb]);
    addr = tk ? pc + ofs : pc + 32'd4;
    mis  = (tk != pt) || (tk && pt && ptgt != pc + ofs);
    dispatch(tag, kind, cb, pc, ofs, pt, ptgt);
    resolve(req, tag, mis, addr);
    check(req, "done_taken", 32'(done_taken), 32'(tk));
    retire(tag);
  endtask

  task automatic t_reset();
    check("R11", "disp_ready", 32'(disp_ready), 32'd1);
    check("R11", "done_valid", 32'(done_valid), 32'd0);
    check("R11", "redir_valid", 32'(redir_valid), 32'd0);
    check("R11", "ret_valid", 32'(ret_valid), 32'd0);
    check("R11", "crl_wr_valid", 32'(crl_wr_valid), 32'd0);
  endtask

  task automatic t_direction();
    cr_bits = 32'h0000_0020;
    run_branch("R4", 4'h1, 2'd1, 5'd5, 32'h1000, 32'h80, 1'b1, 32'h1080);
    run_branch("R4", 4'h2, 2'd2, 5'd5, 32'h2000, 32'h40, 1'b1, 32'h2040);
    run_branch("R4", 4'h3, 2'd0, 5'd0, 32'h3000, 32'h100, 1'b0, 32'h0);
    run_branch("R4", 4'h4, 2'd2, 5'd6, 32'h4000, 32'h10, 1'b1, 32'h4010);
    run_branch("R4", 4'h5, 2'd1, 5'd6, 32'h5000, 32'h10, 1'b1, 32'h5010);
  endtask

  task automatic t_target();
    cr_bits = 32'h0000_0001;
    run_branch("R5", 4'h6, 2'd0, 5'd0, 32'h6000, 32'h20, 1'b1, 32'h6024);
    run_branch("R5", 4'h7, 2'd1, 5'd0, 32'h7000, 32'h30, 1'b1, 32'h7030);
    run_branch("R5", 4'h8, 2'd3, 5'd0, 32'h8000, 32'h30, 1'b0, 32'hDEAD_BEEF);
  endtask

  task automatic t_rs_full();
    cr_bits = '0;
    dispatch(4'hA, 2'd3, 5'd0, 32'h100, 32'h8, 1'b0, 32'h0);
    dispatch(4'hB, 2'd3, 5'd0, 32'h200, 32'h8, 1'b0, 32'h0);
    check("R1", "disp_ready when full", 32'(disp_ready), 32'd0);
    dispatch(4'hC, 2'd0, 5'd0, 32'h300, 32'h8, 1'b0, 32'h0);
    resolve("R3", 4'hA, 1'b0, 32'h0);
    retire(4'hA);
    resolve("R3", 4'hB, 1'b0, 32'h0);
    retire(4'hB);
    expect_no_resolve("R1");
    check("R1", "disp_ready after drain", 32'(disp_ready), 32'd1);
  endtask

  task automatic t_cb_full();
    cr_bits = '0;
    dispatch(4'h1, 2'd3, 5'd0, 32'h10, 32'h8, 1'b0, 32'h0);
    dispatch(4'h2, 2'd3, 5'd0, 32'h20, 32'h8, 1'b0, 32'h0);
    resolve("R2", 4'h1, 1'b0, 32'h0);
    resolve("R2", 4'h2, 1'b0, 32'h0);
    dispatch(4'h3, 2'd3, 5'd0, 32'h30, 32'h8, 1'b0, 32'h0);
    expect_no_resolve("R2");
    retire(4'h1);
    resolve("R2", 4'h3, 1'b0, 32'h0);
    retire(4'h2);
    retire(4'h3);
    @(negedge clk);
    check("R8", "ret_valid empty", 32'(ret_valid), 32'd0);
    cmpl_valid = 1'b1;
    @(negedge clk);
    cmpl_valid = 1'b0;
    run_branch("R8", 4'h4, 2'd3, 5'd0, 32'h40, 32'h8, 1'b0, 32'h0);
  endtask

  task automatic t_flush();
    cr_bits = '0;
    dispatch(4'h5, 2'd0, 5'd0, 32'h1000, 32'h40, 1'b0, 32'h0);
    dispatch(4'h6, 2'd3, 5'd0, 32'h1004, 32'h8, 1'b0, 32'h0);
    resolve("R7", 4'h5, 1'b1, 32'h1040);
    check("R7", "disp_ready after flush", 32'(disp_ready), 32'd1);
    retire(4'h5);
    expect_no_resolve("R7");
    dispatch(4'h7, 2'd3, 5'd0, 32'h2000, 32'h8, 1'b0, 32'h0);
    resolve("R7", 4'h7, 1'b0, 32'h0);
    dispatch(4'h8, 2'd0, 5'd0, 32'h3000, 32'h60, 1'b1, 32'h3064);
    @(negedge clk);
    cr_valid = 1'b1;
    disp_valid = 1'b1; disp_tag = 4'h9; disp_kind = 2'd3;
    @(negedge clk);
    cr_valid = 1'b0;
    disp_valid = 1'b0;
    check("R7", "concurrent mispred", 32'(done_mispred), 32'd1);
    check("R7", "redir_addr", redir_addr, 32'h3060);
    retire(4'h7);
    retire(4'h8);
    expect_no_resolve("R7");
  endtask

  task automatic t_cr_wait();
    cr_bits = '0;
    dispatch(4'hE, 2'd3, 5'd0, 32'h50, 32'h8, 1'b0, 32'h0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9", "held without cr_valid", 32'(done_valid), 32'd0);
    end
    resolve("R9", 4'hE, 1'b0, 32'h0);
    retire(4'hE);
  endtask

  task automatic t_crlogic();
    logic a, b, r;
    cr_bits = 32'h0000_0008;
    for (int op = 0; op < 8; op++) begin
      for (int c = 0; c < 4; c++) begin
        a = c[1];
        b = c[0];
        case (op)
          0: r = a & b;
          1: r = a | b;
          2: r = a ^ b;
          3: r = ~(a & b);
          4: r = ~(a | b);
          5: r = ~(a ^ b);
          6: r = a & ~b;
          default: r = a | ~b;
        endcase
        @(negedge clk);
        crl_valid = 1'b1; crl_op = 3'(op);
        crl_src_a = a ? 5'd3 : 5'd7;
        crl_src_b = b ? 5'd3 : 5'd7;
        crl_dst = 5'(op * 4 + c);
        @(negedge clk);
        crl_valid = 1'b0;
        check("R10", "crl_wr_valid", 32'(crl_wr_valid), 32'd1);
        check("R10", "crl_wr_idx", 32'(crl_wr_idx), 32'(op * 4 + c));
        check("R10", "crl_wr_bit", 32'(crl_wr_bit), 32'(r));
      end
    end
    @(negedge clk);
    check("R10", "crl idle", 32'(crl_wr_valid), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    disp_valid = 1'b0; disp_tag = '0; disp_kind = '0; disp_crbit = '0;
    disp_pc = '0; disp_ofs = '0; disp_pred_taken = 1'b0; disp_pred_tgt = '0;
    cr_valid = 1'b0; cr_bits = '0; cmpl_valid = 1'b0;
    crl_valid = 1'b0; crl_op = '0; crl_src_a = '0; crl_src_b = '0; crl_dst = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_direction();
    t_target();
    t_rs_full();
    t_cb_full();
    t_flush();
    t_cr_wait();
    t_crlogic();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule